// File: doc/BRIEF.md
# Transmit Byte FIFO with Message Tags and Watermark Events

This block is a byte-wide synchronous FIFO. It sits between a processor write port and the serializer that drains bytes for transmission. The processor writes one byte per access. Each stored entry carries an end-of-message tag. The tag comes from a sticky control flag that software raises just before it writes the final byte of a message. That flag drops by itself once the tagged byte has been accepted.

The FIFO has real-time empty and full flags and a free-space count. Software must consult the free-space count, because a write into a full FIFO is silently dropped and nothing reports it. Two latched events are kept:
- a space-available event, raised when the FIFO leaves the full state;
- a low-watermark event, raised when draining takes the fill level below a programmable threshold.

Each event clears when a one is written to it. Each event can drive the interrupt request if its enable is set. A rising edge on the flush control discards all stored bytes.

Top module: `txpkt_fifo`

## Requirements
- R1: After reset, empty=1, full=0, free_cnt=64, eom_pending=0, stat_space=0, stat_lwm=0 and irq=0.
- R2: Bytes leave in the order they were accepted. rd_data/rd_eom show the oldest entry whenever empty=0, and rd_en pops it at the clock edge. A read while empty has no effect.
- R3: free_cnt equals 64 minus the number of stored bytes. empty=1 exactly when 0 bytes are stored, and full=1 exactly when 64 bytes are stored.
- R4: A write while full is discarded, with no error flag. The stored contents and free_cnt are unchanged.
- R5: A pulse on eom_set raises eom_pending. The next accepted byte is stored with rd_eom=1, and eom_pending is 0 after that write. eom_set asserted in the same cycle as a write tags that write. All other bytes are stored with rd_eom=0.
- R6: stat_space becomes 1 in the cycle after a read is accepted while full=1.
- R7: stat_lwm becomes 1 in the cycle after a read, with no write in the same cycle, takes the stored count from lwm_thresh to lwm_thresh-1.
- R8: A one on clr_space or clr_lwm clears the matching latched bit at the next edge. A set event in the same cycle takes priority over the clear.
- R9: irq = (stat_space AND ie_space) OR (stat_lwm AND ie_lwm).
- R10: A 0-to-1 transition of flush_ctl empties the FIFO and clears eom_pending at that edge. Writes and reads in that cycle are ignored. Holding flush_ctl high does not flush again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_ctl | input | 1 | Controller reset control; its rising edge flushes |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| eom_set | input | 1 | Raise the sticky end-of-message flag |
| eom_pending | output | 1 | Sticky end-of-message flag |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head byte |
| rd_eom | output | 1 | Head entry end-of-message tag |
| empty | output | 1 | No bytes stored |
| full | output | 1 | 64 bytes stored |
| free_cnt | output | 7 | Free byte locations |
| lwm_thresh | input | 7 | Low-watermark threshold |
| clr_space | input | 1 | Write-one clear of stat_space |
| clr_lwm | input | 1 | Write-one clear of stat_lwm |
| ie_space | input | 1 | Interrupt enable for stat_space |
| ie_lwm | input | 1 | Interrupt enable for stat_lwm |
| stat_space | output | 1 | Latched space-available event |
| stat_lwm | output | 1 | Latched low-watermark event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions are checked on every cycle. They cover the following properties:
- the stored count never exceeds the depth;
- the FIFO stays full when nothing drains it;
- the space and watermark events latch after their triggering read;
- a flush empties the FIFO;
- the end-of-message flag drops after an accepted write;
- irq stays low with both enables off.

Some behaviour only the bench scenarios can show:
- byte order and tag placement across messages;
- the fact that a discarded write leaves the contents intact;
- set-over-clear priority;
- a flush ignoring a write in its own cycle and not repeating while the control is held high.

// File: rtl/txpkt_fifo.sv
module txpkt_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_ctl,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             eom_set,
  output logic             eom_pending,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_eom,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] free_cnt,
  input  logic [CNT_W-1:0] lwm_thresh,
  input  logic             clr_space,
  input  logic             clr_lwm,
  input  logic             ie_space,
  input  logic             ie_lwm,
  output logic             stat_space,
  output logic             stat_lwm,
  output logic             irq
);

  logic [DW:0]      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             flush_q;

  wire flush_rise = flush_ctl & ~flush_q;
  wire do_wr      = wr_en & ~full & ~flush_rise;
  wire do_rd      = rd_en & ~empty & ~flush_rise;
  wire space_ev   = do_rd & full;
  wire lwm_ev     = do_rd & ~do_wr & (count == lwm_thresh);

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign free_cnt = CNT_W'(DEPTH) - count;
  assign rd_data  = mem[rd_ptr][DW-1:0];
  assign rd_eom   = mem[rd_ptr][DW];
  assign irq      = (stat_space & ie_space) | (stat_lwm & ie_lwm);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= {eom_pending | eom_set, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q     <= 1'b0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      eom_pending <= 1'b0;
      stat_space  <= 1'b0;
      stat_lwm    <= 1'b0;
    end else begin
      flush_q    <= flush_ctl;
      stat_space <= space_ev | (stat_space & ~clr_space);
      stat_lwm   <= lwm_ev | (stat_lwm & ~clr_lwm);
      if (flush_rise) begin
        wr_ptr      <= '0;
        rd_ptr      <= '0;
        count       <= '0;
        eom_pending <= 1'b0;
      end else begin
        if (do_wr) wr_ptr <= bump(wr_ptr);
        if (do_rd) rd_ptr <= bump(rd_ptr);
        count       <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
        eom_pending <= do_wr ? 1'b0 : (eom_pending | eom_set);
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && !flush_rise) |=> full); // R4
  AST_SPACE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_en && !flush_rise) |=> stat_space); // R6
  AST_LWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr_en && !flush_rise &&
     free_cnt == CNT_W'(DEPTH) - lwm_thresh) |=> stat_lwm); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rise |=> (empty && !eom_pending)); // R10
  AST_EOM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !flush_rise) |=> !eom_pending); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_space && !ie_lwm) |-> !irq); // R9

endmodule

// File: tb/txpkt_fifo_bench.sv
module txpkt_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic flush_ctl = 0, wr_en = 0, eom_set = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] lwm_thresh = 0;
  logic clr_space = 0, clr_lwm = 0, ie_space = 0, ie_lwm = 0;
  logic eom_pending, rd_eom, empty, full, stat_space, stat_lwm, irq;
  logic [7:0] rd_data;
  logic [6:0] free_cnt;

  int checks = 0, failures = 0, mcnt = 0;
  logic [8:0] sb[$];

  always #2 clk = ~clk;

  txpkt_fifo u_txpkt_fifo (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit eom);
    wr_data = d; wr_en = 1; eom_set = eom;
    @(posedge clk); @(negedge clk);
    wr_en = 0; eom_set = 0;
    if (mcnt < 64) begin sb.push_back({eom, d}); mcnt++; end
  endtask

  task automatic rd();
    logic [8:0] e;
    if (sb.size() > 0) begin
      e = sb[0];
      chk({rd_eom, rd_data} == e, "R2/R5 head", {rd_eom, rd_data}, e);
    end
    rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    if (sb.size() > 0) begin void'(sb.pop_front()); mcnt--; end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(empty && !full, "R1 flags", {empty, full}, 2);
    chk(free_cnt == 64, "R1 free", free_cnt, 64);
    chk(!stat_space && !stat_lwm && !irq && !eom_pending, "R1 status",
        {stat_space, stat_lwm, irq, eom_pending}, 0);

    wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 1);
    chk(free_cnt == 61, "R3 free after 3", free_cnt, 61);
    chk(!eom_pending, "R5 inline eom cleared", eom_pending, 0);
    eom_set = 1; @(posedge clk); @(negedge clk); eom_set = 0;
    chk(eom_pending, "R5 sticky set", eom_pending, 1);
    wr(8'h44, 1);
    chk(!eom_pending, "R5 self clear", eom_pending, 0);
    wr(8'h55, 0);
    repeat (5) rd();
    chk(empty && free_cnt == 64, "R3 empty again", free_cnt, 64);

    rd();
    chk(empty && free_cnt == 64, "R2 read when empty", free_cnt, 64);

    for (int i = 0; i < 64; i++) wr(8'(i + 8'h80), (i % 16) == 15);
    chk(full && free_cnt == 0, "R3 full", free_cnt, 0);
    wr(8'hEE, 0);
    chk(full && free_cnt == 0, "R4 overflow dropped", free_cnt, 0);
    chk(!stat_space, "R6 no event yet", stat_space, 0);
    rd();
    chk(stat_space, "R6 space event", stat_space, 1);
    chk(!irq, "R9 masked", irq, 0);
    ie_space = 1; #1;
    chk(irq, "R9 enabled", irq, 1);
    clr_space = 1; @(posedge clk); @(negedge clk); clr_space = 0;
    chk(!stat_space && !irq, "R8 w1c space", stat_space, 0);

    lwm_thresh = 60;
    repeat (3) rd();
    chk(free_cnt == 4 && !stat_lwm, "R7 at threshold", stat_lwm, 0);
    rd();
    chk(stat_lwm, "R7 below threshold", stat_lwm, 1);
    ie_space = 0; ie_lwm = 1; #1;
    chk(irq, "R9 lwm irq", irq, 1);
    clr_lwm = 1; @(posedge clk); @(negedge clk); clr_lwm = 0;
    chk(!stat_lwm, "R8 w1c lwm", stat_lwm, 0);
    ie_lwm = 0;

    for (int i = 0; i < 5; i++) wr(8'(8'hC0 + i), 0);
    chk(full, "R3 refilled", full, 1);
    clr_space = 1; rd(); clr_space = 0;
    chk(stat_space, "R8 set beats clear", stat_space, 1);

    rd();
    chk(!empty && free_cnt == 2, "R3 before flush", free_cnt, 2);
    eom_set = 1; @(posedge clk); @(negedge clk); eom_set = 0;
    flush_ctl = 1; wr_en = 1; wr_data = 8'h99;
    @(posedge clk); @(negedge clk); wr_en = 0;
    sb.delete(); mcnt = 0;
    chk(empty && free_cnt == 64, "R10 flush empties", free_cnt, 64);
    chk(!eom_pending, "R10 flush clears eom", eom_pending, 0);
    wr(8'h5A, 0);
    chk(free_cnt == 63, "R10 level no reflush", free_cnt, 63);
    flush_ctl = 0;
    rd();
    chk(empty, "R2 drained", empty, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule